// File: doc/BRIEF.md
# Serial Test-Port Memory Access Controller

This block is a boundary-scan test access port: a standard sixteen-state controller, a 5-bit instruction register, and a set of data registers. Besides the usual bypass and user-code registers it has private instructions. With them a host on the serial port can set an 8-bit byte address, read or write the byte at that address, choose one of three address pages, and ask for a reboot. The page bits extend the byte address to a 10-bit memory address {page, byte}. Page 0 (000h-0FFh) is the default page. Page 2 (200h-2FFh) is the flash page and page 3 (300h-3FFh) is the user flash page.

Writes to the default page go straight to a synchronous memory port as a one-cycle write strobe. Writes to either flash page go to a gatherer instead. It collects eight bytes that start on an 8-byte boundary and hands them on as one 64-bit line with a single commit pulse. A burst that starts off the boundary, or that a new instruction breaks, is thrown away and sets a sticky error flag. The address advances by one after every read and every write, so a burst needs only one address load.

All state steps on the rising edge of the test clock. TDO changes on the falling edge. The controller states are Test-Logic-Reset, Run-Test/Idle, Select-DR-Scan, Capture-DR, Shift-DR, Exit1-DR, Pause-DR, Exit2-DR, Update-DR, Select-IR-Scan, Capture-IR, Shift-IR, Exit1-IR, Pause-IR, Exit2-IR and Update-IR. The transitions follow the standard TMS graph:
- Reset goes to Idle on TMS=0.
- Idle goes to Select-DR on TMS=1.
- Select-DR goes to Capture-DR on 0, or to Select-IR on 1.
- Select-IR goes to Capture-IR on 0, or back to Reset on 1.
- Capture goes to Shift on 0, or to Exit1 on 1.
- Shift stays in Shift on 0, or goes to Exit1 on 1.
- Exit1 goes to Pause on 0, or to Update on 1.
- Pause stays in Pause on 0, or goes to Exit2 on 1.
- Exit2 goes back to Shift on 0, or to Update on 1.
- Update goes to Idle on 0, or to Select-DR on 1.

Top module: `jtag_mem_tap`

## Requirements
- R1: An asynchronous low trst_n, or five rising test-clock edges with TMS high, puts the controller in Test-Logic-Reset. There the current instruction becomes BYPASS (11111), the page returns to 0 and the burst is dropped.
- R2: The instruction register is 5 bits wide and shifts LSB first. Capture-IR loads 00001, and Update-IR makes the shifted value current. The opcodes are USERCODE 00010, LOAD-ADDRESS 01000, READ 01001, WRITE 01010, REBOOT 01011, FLASH-PAGE-ON 01100, FLASH-PAGE-OFF 01101, USER-PAGE-ON 01110, USER-PAGE-OFF 01111 and BYPASS 11111.
- R3: Under USERCODE, Capture-DR loads a 32-bit word. Its bits [7:0] are user_id, bits [14:8] are slave_id and bits [31:15] are zero. Shift-DR sends the word out LSB first.
- R4: Under LOAD-ADDRESS an 8-bit register is in the scan path. Capture-DR loads the current byte address into it, and Update-DR makes the shifted value the new byte address. Under WRITE an 8-bit register is in the scan path. If the page is 0, Update-DR pulses mem_wr for one cycle with mem_addr={page,byte} and mem_wdata equal to the shifted byte. The byte address then goes up by one and wraps inside the page.
- R5: Under READ, Capture-DR pulses mem_rd and loads mem_rdata from the current address into an 8-bit register. That register shifts out LSB first, and the byte address goes up by one on the same edge.
- R6: Under BYPASS, REBOOT, any page instruction or any opcode not listed, a 1-bit register that captures 0 is in the scan path. TDO then repeats TDI one shift later.
- R7: FLASH-PAGE-ON selects page 2 (200h-2FFh) and FLASH-PAGE-OFF selects page 0. A WRITE while the page is 2 or 3 never pulses mem_wr and goes to the burst gatherer instead.
- R8: USER-PAGE-ON moves page 2 to page 3 (300h-3FFh) and does nothing on any other page. USER-PAGE-OFF moves page 3 to page 2 and does nothing on any other page.
- R9: A flash burst must start at a byte address whose 3 low bits are 000 and must be made of eight WRITE updates. One cycle after the eighth update, flash_commit is high for one cycle. flash_base then holds the start address and flash_line bits [8k+7:8k] hold the k-th byte. A start off the boundary, or any Update-IR before the eighth byte, drops the burst without a commit and sets burst_err.
- R10: reboot_req is high whenever REBOOT is the current instruction, from the edge that latches it.
- R11: Once set, burst_err stays high. Only Test-Logic-Reset clears it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck | input | 1 | Test clock |
| trst_n | input | 1 | Asynchronous test reset, active low |
| tms | input | 1 | Test mode select |
| tdi | input | 1 | Serial data in |
| user_id | input | 8 | User identifier placed in the user code |
| slave_id | input | 7 | Serial slave identifier placed in the user code |
| mem_rdata | input | 8 | Read data for mem_addr |
| tdo | output | 1 | Serial data out, changes on falling tck |
| mem_addr | output | 10 | Memory address {page, byte} |
| mem_wdata | output | 8 | Memory write data |
| mem_rd | output | 1 | Read strobe |
| mem_wr | output | 1 | Write strobe, default page only |
| flash_commit | output | 1 | One-cycle commit of a gathered line |
| flash_base | output | 10 | Start address of the committed line |
| flash_line | output | 64 | Eight gathered bytes |
| burst_err | output | 1 | Sticky flash burst error |
| reboot_req | output | 1 | Reboot request |

## Verification
The hardest case to reach from the ports is a flash burst that is cut short. Only a complete instruction scan can end one, so the bench writes three bytes into an aligned burst and then loads a new instruction. It then checks that no commit appears, that the error flag rises, and that a later full burst still commits with the error flag still set. The user-page change that must be ignored needs a similar path. The bench leaves the flash page, issues the user-page instruction, and then makes a default-page write land at 0xx. That shows the page stayed at 0.

// File: rtl/jtag_mem_pkg.sv
package jtag_mem_pkg;

    localparam int IR_W   = 5;
    localparam int PAGE_W = 2;

    typedef enum logic [3:0] {
        ST_RESET, ST_IDLE,
        ST_SEL_DR, ST_CAP_DR, ST_SH_DR, ST_EX1_DR, ST_PA_DR, ST_EX2_DR, ST_UPD_DR,
        ST_SEL_IR, ST_CAP_IR, ST_SH_IR, ST_EX1_IR, ST_PA_IR, ST_EX2_IR, ST_UPD_IR
    } tap_state_t;

    typedef enum logic [2:0] {
        DR_BYP, DR_UC, DR_ADR, DR_RD, DR_WR
    } dr_sel_t;

    localparam logic [IR_W-1:0] OP_USERCODE = 5'b00010;
    localparam logic [IR_W-1:0] OP_LDADR    = 5'b01000;
    localparam logic [IR_W-1:0] OP_READ     = 5'b01001;
    localparam logic [IR_W-1:0] OP_WRITE    = 5'b01010;
    localparam logic [IR_W-1:0] OP_REBOOT   = 5'b01011;
    localparam logic [IR_W-1:0] OP_FLON     = 5'b01100;
    localparam logic [IR_W-1:0] OP_FLOFF    = 5'b01101;
    localparam logic [IR_W-1:0] OP_USRON    = 5'b01110;
    localparam logic [IR_W-1:0] OP_USROFF   = 5'b01111;
    localparam logic [IR_W-1:0] OP_BYPASS   = 5'b11111;
    localparam logic [IR_W-1:0] IR_CAPTURE  = 5'b00001;

    localparam logic [PAGE_W-1:0] PG_DEFAULT = 2'b00;
    localparam logic [PAGE_W-1:0] PG_FLASH   = 2'b10;
    localparam logic [PAGE_W-1:0] PG_USER    = 2'b11;

endpackage

// File: rtl/jtag_tap_fsm.sv
module jtag_tap_fsm
    import jtag_mem_pkg::*;
(
    input  logic       tck,
    input  logic       trst_n,
    input  logic       tms,
    output tap_state_t state
);

    tap_state_t nxt;

    always_comb begin
        nxt = state;
        unique case (state)
            ST_RESET:  nxt = tms ? ST_RESET  : ST_IDLE;
            ST_IDLE:   nxt = tms ? ST_SEL_DR : ST_IDLE;
            ST_SEL_DR: nxt = tms ? ST_SEL_IR : ST_CAP_DR;
            ST_CAP_DR: nxt = tms ? ST_EX1_DR : ST_SH_DR;
            ST_SH_DR:  nxt = tms ? ST_EX1_DR : ST_SH_DR;
            ST_EX1_DR: nxt = tms ? ST_UPD_DR : ST_PA_DR;
            ST_PA_DR:  nxt = tms ? ST_EX2_DR : ST_PA_DR;
            ST_EX2_DR: nxt = tms ? ST_UPD_DR : ST_SH_DR;
            ST_UPD_DR: nxt = tms ? ST_SEL_DR : ST_IDLE;
            ST_SEL_IR: nxt = tms ? ST_RESET  : ST_CAP_IR;
            ST_CAP_IR: nxt = tms ? ST_EX1_IR : ST_SH_IR;
            ST_SH_IR:  nxt = tms ? ST_EX1_IR : ST_SH_IR;
            ST_EX1_IR: nxt = tms ? ST_UPD_IR : ST_PA_IR;
            ST_PA_IR:  nxt = tms ? ST_EX2_IR : ST_PA_IR;
            ST_EX2_IR: nxt = tms ? ST_UPD_IR : ST_SH_IR;
            ST_UPD_IR: nxt = tms ? ST_SEL_DR : ST_IDLE;
            default:   nxt = ST_RESET;
        endcase
    end

    always_ff @(posedge tck or negedge trst_n) begin
        if (!trst_n) state <= ST_RESET;
        else         state <= nxt;
    end

    // R1: five TMS-high edges always end in Test-Logic-Reset
    a_r1_five_tms_reset: assert property (@(posedge tck) disable iff (!trst_n)
        ($past(tms, 1) && $past(tms, 2) && $past(tms, 3) && $past(tms, 4) && $past(tms, 5))
        |-> (state == ST_RESET));

    // R1: TMS high holds the reset state
    a_r1_reset_holds: assert property (@(posedge tck) disable iff (!trst_n)
        (state == ST_RESET && tms) |=> (state == ST_RESET));

endmodule

// File: rtl/flash_burst_gather.sv
module flash_burst_gather #(
    parameter int ADDR_W = 10,
    parameter int DATA_W = 8,
    parameter int BEATS  = 8
) (
    input  logic                     tck,
    input  logic                     rst_n,
    input  logic                     clr,
    input  logic                     beat,
    input  logic                     abort,
    input  logic [ADDR_W-1:0]        addr,
    input  logic [DATA_W-1:0]        data,
    output logic                     commit,
    output logic [ADDR_W-1:0]        base,
    output logic [BEATS*DATA_W-1:0]  line,
    output logic                     err
);

    localparam int CNT_W = $clog2(BEATS);

    logic             active;
    logic [CNT_W-1:0] cnt;

    always_ff @(posedge tck or negedge rst_n) begin
        if (!rst_n) begin
            active <= 1'b0;
            cnt    <= '0;
            err    <= 1'b0;
            commit <= 1'b0;
            base   <= '0;
            line   <= '0;
        end else begin
            commit <= 1'b0;
            if (clr) begin
                active <= 1'b0;
                cnt    <= '0;
                err    <= 1'b0;
            end else if (abort && active) begin
                active <= 1'b0;
                cnt    <= '0;
                err    <= 1'b1;
            end else if (beat) begin
                if (!active) begin
                    if (addr[CNT_W-1:0] != '0) begin
                        err <= 1'b1;
                    end else begin
                        active            <= 1'b1;
                        cnt               <= CNT_W'(1);
                        base              <= addr;
                        line[DATA_W-1:0]  <= data;
                    end
                end else begin
                    line[int'(cnt)*DATA_W +: DATA_W] <= data;
                    if (cnt == CNT_W'(BEATS-1)) begin
                        commit <= 1'b1;
                        active <= 1'b0;
                        cnt    <= '0;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
            end
        end
    end

    // R9: a committed line always starts on a burst boundary
    a_r9_commit_aligned: assert property (@(posedge tck) disable iff (!rst_n)
        commit |-> (base[CNT_W-1:0] == '0));

    // R9: an interrupted burst raises the error and never commits
    a_r9_abort_no_commit: assert property (@(posedge tck) disable iff (!rst_n)
        (abort && active && !clr) |=> (err && !commit));

    // R11: the error flag is sticky until reset state
    a_r11_err_sticky: assert property (@(posedge tck) disable iff (!rst_n)
        (err && !clr) |=> err);

endmodule

// File: rtl/jtag_mem_tap.sv
module jtag_mem_tap
    import jtag_mem_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 8,
    parameter int SID_W  = 7,
    parameter int UC_W   = 32,
    parameter int BEATS  = 8
) (
    input  logic                        tck,
    input  logic                        trst_n,
    input  logic                        tms,
    input  logic                        tdi,
    input  logic [DATA_W-1:0]           user_id,
    input  logic [SID_W-1:0]            slave_id,
    input  logic [DATA_W-1:0]           mem_rdata,
    output logic                        tdo,
    output logic [PAGE_W+ADDR_W-1:0]    mem_addr,
    output logic [DATA_W-1:0]           mem_wdata,
    output logic                        mem_rd,
    output logic                        mem_wr,
    output logic                        flash_commit,
    output logic [PAGE_W+ADDR_W-1:0]    flash_base,
    output logic [BEATS*DATA_W-1:0]     flash_line,
    output logic                        burst_err,
    output logic                        reboot_req
);

    localparam int MADDR_W = PAGE_W + ADDR_W;
    localparam int UC_PAD  = UC_W - DATA_W - SID_W;

    tap_state_t            state;
    dr_sel_t               sel;
    logic [IR_W-1:0]       ir_sr, ir_q;
    logic [PAGE_W-1:0]     page_q;
    logic [ADDR_W-1:0]     addr_q, sr_adr;
    logic [DATA_W-1:0]     sr_rd, sr_wr;
    logic [UC_W-1:0]       sr_uc;
    logic                  sr_byp;
    logic                  dr_bit;
    logic                  wr_beat, fl_beat;
    logic [UC_W-1:0]       usercode;

    jtag_tap_fsm u_fsm (
        .tck    (tck),
        .trst_n (trst_n),
        .tms    (tms),
        .state  (state)
    );

    assign usercode = {{UC_PAD{1'b0}}, slave_id, user_id};

    always_comb begin
        unique case (ir_q)
            OP_USERCODE: sel = DR_UC;
            OP_LDADR:    sel = DR_ADR;
            OP_READ:     sel = DR_RD;
            OP_WRITE:    sel = DR_WR;
            default:     sel = DR_BYP;
        endcase
    end

    // register process: instruction, page, address and scan chains
    always_ff @(posedge tck or negedge trst_n) begin
        if (!trst_n) begin
            ir_sr  <= IR_CAPTURE;
            ir_q   <= OP_BYPASS;
            page_q <= PG_DEFAULT;
            addr_q <= '0;
            sr_adr <= '0;
            sr_rd  <= '0;
            sr_wr  <= '0;
            sr_uc  <= '0;
            sr_byp <= 1'b0;
        end else if (state == ST_RESET) begin
            ir_q   <= OP_BYPASS;
            page_q <= PG_DEFAULT;
        end else begin
            unique case (state)
                ST_CAP_IR: ir_sr <= IR_CAPTURE;
                ST_SH_IR:  ir_sr <= {tdi, ir_sr[IR_W-1:1]};
                ST_UPD_IR: begin
                    ir_q <= ir_sr;
                    unique case (ir_sr)
                        OP_FLON:   page_q <= PG_FLASH;
                        OP_FLOFF:  page_q <= PG_DEFAULT;
                        OP_USRON:  if (page_q == PG_FLASH) page_q <= PG_USER;
                        OP_USROFF: if (page_q == PG_USER)  page_q <= PG_FLASH;
                        default: ;
                    endcase
                end
                ST_CAP_DR: begin
                    unique case (sel)
                        DR_UC:  sr_uc  <= usercode;
                        DR_ADR: sr_adr <= addr_q;
                        DR_RD: begin
                            sr_rd  <= mem_rdata;
                            addr_q <= addr_q + 1'b1;
                        end
                        DR_WR:  sr_wr  <= '0;
                        default: sr_byp <= 1'b0;
                    endcase
                end
                ST_SH_DR: begin
                    unique case (sel)
                        DR_UC:  sr_uc  <= {tdi, sr_uc[UC_W-1:1]};
                        DR_ADR: sr_adr <= {tdi, sr_adr[ADDR_W-1:1]};
                        DR_RD:  sr_rd  <= {tdi, sr_rd[DATA_W-1:1]};
                        DR_WR:  sr_wr  <= {tdi, sr_wr[DATA_W-1:1]};
                        default: sr_byp <= tdi;
                    endcase
                end
                ST_UPD_DR: begin
                    if (sel == DR_ADR) addr_q <= sr_adr;
                    else if (sel == DR_WR) addr_q <= addr_q + 1'b1;
                end
                default: ;
            endcase
        end
    end

    // output process: strobes, address and serial output
    always_comb begin
        unique case (sel)
            DR_UC:   dr_bit = sr_uc[0];
            DR_ADR:  dr_bit = sr_adr[0];
            DR_RD:   dr_bit = sr_rd[0];
            DR_WR:   dr_bit = sr_wr[0];
            default: dr_bit = sr_byp;
        endcase
    end

    assign mem_addr   = {page_q, addr_q};
    assign mem_wdata  = sr_wr;
    assign mem_rd     = (state == ST_CAP_DR) && (sel == DR_RD);
    assign wr_beat    = (state == ST_UPD_DR) && (sel == DR_WR);
    assign mem_wr     = wr_beat && (page_q == PG_DEFAULT);
    assign fl_beat    = wr_beat && (page_q != PG_DEFAULT);
    assign reboot_req = (ir_q == OP_REBOOT);

    always_ff @(negedge tck or negedge trst_n) begin
        if (!trst_n)                tdo <= 1'b0;
        else if (state == ST_SH_IR) tdo <= ir_sr[0];
        else if (state == ST_SH_DR) tdo <= dr_bit;
        else                        tdo <= 1'b0;
    end

    flash_burst_gather #(
        .ADDR_W (MADDR_W),
        .DATA_W (DATA_W),
        .BEATS  (BEATS)
    ) u_gather (
        .tck    (tck),
        .rst_n  (trst_n),
        .clr    (state == ST_RESET),
        .beat   (fl_beat),
        .abort  (state == ST_UPD_IR),
        .addr   (mem_addr),
        .data   (sr_wr),
        .commit (flash_commit),
        .base   (flash_base),
        .line   (flash_line),
        .err    (burst_err)
    );

    // R4: the byte address advances after every write update
    a_r4_write_advances: assert property (@(posedge tck) disable iff (!trst_n)
        wr_beat |=> (mem_addr[ADDR_W-1:0] == ADDR_W'($past(mem_addr[ADDR_W-1:0]) + 1'b1)));

    // R5: the byte address advances after every read capture
    a_r5_read_advances: assert property (@(posedge tck) disable iff (!trst_n)
        mem_rd |=> (mem_addr[ADDR_W-1:0] == ADDR_W'($past(mem_addr[ADDR_W-1:0]) + 1'b1)));

    // R7: read, write and commit strobes never overlap
    a_r7_strobes_exclusive: assert property (@(posedge tck) disable iff (!trst_n)
        $onehot0({mem_rd, mem_wr, flash_commit}));

    // R10: latching the reboot opcode raises the request on the next cycle
    a_r10_reboot_latched: assert property (@(posedge tck) disable iff (!trst_n)
        (state == ST_UPD_IR && ir_sr == OP_REBOOT) |=> reboot_req);

endmodule

// File: tb/tb_jtag_mem_tap.sv
module tb_jtag_mem_tap;

    logic        tck = 1'b0;
    logic        trst_n = 1'b0;
    logic        tms = 1'b1;
    logic        tdi = 1'b0;
    logic [7:0]  user_id = 8'hA5;
    logic [6:0]  slave_id = 7'h3C;
    logic [7:0]  mem_rdata;
    logic        tdo;
    logic [9:0]  mem_addr;
    logic [7:0]  mem_wdata;
    logic        mem_rd, mem_wr, flash_commit, burst_err, reboot_req;
    logic [9:0]  flash_base;
    logic [63:0] flash_line;

    int n_chk = 0;
    int n_fail = 0;
    int wr_cnt = 0;
    int commits = 0;
    logic [9:0]  c_base;
    logic [63:0] c_line;
    logic [7:0]  mem [0:1023];

    always #4 tck = ~tck;

    jtag_mem_tap dut (
        .tck(tck), .trst_n(trst_n), .tms(tms), .tdi(tdi),
        .user_id(user_id), .slave_id(slave_id), .mem_rdata(mem_rdata),
        .tdo(tdo), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_rd(mem_rd), .mem_wr(mem_wr), .flash_commit(flash_commit),
        .flash_base(flash_base), .flash_line(flash_line),
        .burst_err(burst_err), .reboot_req(reboot_req)
    );

    // behavioural memory and commit observer
    assign mem_rdata = mem[mem_addr];
    always @(posedge tck) begin
        if (mem_wr) begin
            mem[mem_addr] <= mem_wdata;
            wr_cnt <= wr_cnt + 1;
        end
        if (flash_commit) begin
            commits <= commits + 1;
            c_base  <= flash_base;
            c_line  <= flash_line;
        end
    end

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic step(input logic m, input logic d, output logic o);
        @(negedge tck);
        #1;
        tms = m;
        tdi = d;
        o = tdo;
        @(posedge tck);
        #1;
    endtask

    task automatic idle(input int n);
        logic o;
        for (int i = 0; i < n; i++) step(1'b0, 1'b0, o);
    endtask

    task automatic tms_reset();
        logic o;
        for (int i = 0; i < 5; i++) step(1'b1, 1'b0, o);
        step(1'b0, 1'b0, o);
    endtask

    task automatic ir_scan(input logic [4:0] op, output logic [4:0] cap);
        logic o;
        step(1'b1, 1'b0, o);
        step(1'b1, 1'b0, o);
        step(1'b0, 1'b0, o);
        step(1'b0, 1'b0, o);
        for (int i = 0; i < 5; i++) begin
            step(i == 4, op[i], o);
            cap[i] = o;
        end
        step(1'b1, 1'b0, o);
        step(1'b0, 1'b0, o);
    endtask

    task automatic ir(input logic [4:0] op);
        logic [4:0] c;
        ir_scan(op, c);
    endtask

    task automatic dr_scan(input int n, input logic [31:0] din, output logic [31:0] dout);
        logic o;
        dout = '0;
        step(1'b1, 1'b0, o);
        step(1'b0, 1'b0, o);
        step(1'b0, 1'b0, o);
        for (int i = 0; i < n; i++) begin
            step(i == n - 1, din[i], o);
            dout[i] = o;
        end
        step(1'b1, 1'b0, o);
        step(1'b0, 1'b0, o);
    endtask

    task automatic dr(input int n, input logic [31:0] din);
        logic [31:0] d;
        dr_scan(n, din, d);
    endtask

    task automatic burst(input logic [7:0] start, input logic [7:0] seed);
        ir(5'b01000);
        dr(8, {24'h0, start});
        ir(5'b01010);
        for (int k = 0; k < 8; k++) dr(8, {24'h0, 8'(seed + 8'(k))});
        idle(2);
    endtask

    function automatic logic [63:0] line_of(input logic [7:0] seed);
        logic [63:0] l;
        for (int k = 0; k < 8; k++) l[k*8 +: 8] = 8'(seed + 8'(k));
        return l;
    endfunction

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    initial begin
        #(8 * 200000);
        n_fail++;
        $display("FAIL watchdog actual=hung expected=done");
        summary();
    end

    initial begin
        logic [31:0] d;
        logic [4:0]  c;
        int base_commits;
        #20;
        trst_n = 1'b1;
        idle(2);

        // R1 reset state, R6 bypass after reset
        chk("R1 reboot_req after reset", reboot_req, 0);
        chk("R1 burst_err after reset", burst_err, 0);
        dr_scan(4, 32'hB, d);
        chk("R6 bypass delay after reset", d[3:0], 4'b0110);

        // R2 instruction capture
        ir_scan(5'b00010, c);
        chk("R2 IR capture pattern", c, 5'b00001);

        // R3 user code
        dr_scan(32, 32'h0, d);
        chk("R3 user code", d, {17'h0, 7'h3C, 8'hA5});

        // R1 five TMS-high edges
        tms_reset();
        dr_scan(4, 32'h5, d);
        chk("R1 TMS reset selects bypass", d[3:0], 4'b1010);

        // R4 default page writes with increment
        ir(5'b01000);
        dr(8, 32'h10);
        ir(5'b01010);
        dr(8, 32'h5A);
        dr(8, 32'h6B);
        idle(1);
        chk("R4 write at 010h", mem[10'h010], 8'h5A);
        chk("R4 write at 011h", mem[10'h011], 8'h6B);
        chk("R4 write strobe count", wr_cnt, 2);
        ir(5'b01000);
        dr_scan(8, 32'h10, d);
        chk("R4 address capture", d[7:0], 8'h12);

        // R5 reads with increment
        ir(5'b01001);
        dr_scan(8, 32'h0, d);
        chk("R5 read 010h", d[7:0], 8'h5A);
        dr_scan(8, 32'h0, d);
        chk("R5 read 011h", d[7:0], 8'h6B);

        // R6 unknown opcode uses bypass
        ir(5'b10101);
        dr_scan(4, 32'h9, d);
        chk("R6 unknown opcode bypass", d[3:0], 4'b0010);

        // R10 reboot
        ir(5'b01011);
        chk("R10 reboot raised", reboot_req, 1);
        ir(5'b11111);
        chk("R10 reboot dropped", reboot_req, 0);

        // R7 flash page burst
        ir(5'b01100);
        burst(8'h08, 8'h11);
        chk("R7 flash commit count", commits, 1);
        chk("R9 flash base 208h", c_base, 10'h208);
        chk("R9 flash line", c_line, line_of(8'h11));
        chk("R7 no mem_wr on flash page", wr_cnt, 2);
        chk("R9 no error on aligned burst", burst_err, 0);

        // R8 user page and back
        ir(5'b01110);
        burst(8'h20, 8'h40);
        chk("R8 user page base 320h", c_base, 10'h320);
        chk("R8 user page line", c_line, line_of(8'h40));
        ir(5'b01111);
        burst(8'h30, 8'h70);
        chk("R8 back to flash page 230h", c_base, 10'h230);
        ir(5'b01101);
        ir(5'b01110);
        ir(5'b01000);
        dr(8, 32'h40);
        ir(5'b01010);
        dr(8, 32'h99);
        idle(1);
        chk("R8 user-page-on ignored on default page", mem[10'h040], 8'h99);
        chk("R8 write strobe after ignore", wr_cnt, 3);

        // R9 unaligned start
        base_commits = commits;
        ir(5'b01100);
        ir(5'b01000);
        dr(8, 32'h03);
        ir(5'b01010);
        dr(8, 32'hC3);
        idle(2);
        chk("R9 unaligned sets error", burst_err, 1);
        chk("R9 unaligned no commit", commits, base_commits);

        // R11 cleared only by reset; R7 reset returns to default page
        ir(5'b11111);
        chk("R11 error sticky over instruction", burst_err, 1);
        tms_reset();
        chk("R11 error cleared in reset", burst_err, 0);
        ir(5'b01000);
        dr(8, 32'h50);
        ir(5'b01010);
        dr(8, 32'h77);
        idle(1);
        chk("R7 reset returns to default page", mem[10'h050], 8'h77);

        // R9 interrupted burst, then a full burst still commits
        ir(5'b01100);
        ir(5'b01000);
        dr(8, 32'h48);
        ir(5'b01010);
        dr(8, 32'h01);
        dr(8, 32'h02);
        dr(8, 32'h03);
        ir(5'b11111);
        idle(2);
        chk("R9 interrupted sets error", burst_err, 1);
        chk("R9 interrupted no commit", commits, base_commits);
        burst(8'h50, 8'hA0);
        chk("R9 later burst commits", commits, base_commits + 1);
        chk("R9 later burst base 250h", c_base, 10'h250);
        chk("R11 error still set", burst_err, 1);

        summary();
    end

endmodule